// File: doc/BRIEF.md
# Open-Drain Clock/Data Pin Pair Control Register

This block is one 32-bit control word that lets software bit-bang a two-wire serial bus. It drives a clock pin and a data pin, and it reads back the level on each. Each pin gets its own byte-wide lane in the word. A lane holds four things: a drive-enable (direction) field, a drive-level (value) field, a pull-up-disable bit and a read-only sampled-input bit. The direction and value fields each have a write-only companion enable bit. Because of these enable bits, one store can change a single field of a single pin and leave every other field as it was.

Both pins are open-drain. Software makes a pin high by turning the driver off and letting the external pull-up take the line. It makes a pin low by turning the driver on with a stored value of 0. The live line level of each pin goes through a multi-flop synchroniser before it reaches the read word. Software therefore reads the sampled level after it has released a pin. The block does no protocol sequencing; every edge on the bus comes from a software write.

Top module: `odgpio_pair`

## Requirements
- R1: In pin p's lane (base 8*p; pin 0 is clock, pin 1 is data), a write with bit base+1 set loads the direction field (bit base+0, 1 = drive) from the write data. A write with bit base+3 set loads the value field (bit base+2). The new value is visible on the cycle after the write edge.
- R2: When bit base+1 or bit base+3 is clear in a write, the matching direction or value field keeps its old contents, whatever data is written to it. A cycle with no write changes neither field.
- R3: Every write loads the pull-up-disable bit (bit base+5) of each lane, whatever the enable bits hold. A cycle with no write leaves it unchanged. It appears on `pin_pud[p]`.
- R4: The enable bits (base+1, base+3) always read as 0. Every bit outside the defined fields also reads as 0.
- R5: `pin_oe[p]` equals the stored direction field and `pin_out[p]` equals the stored value field. The read word returns both, together with the pull-up-disable bit.
- R6: Read bit base+4 shows `pin_in[p]` as it was sampled two clock edges earlier, through a two-flop synchroniser that resets to 0.
- R7: During reset the read word is all zero, and `pin_oe`, `pin_out` and `pin_pud` are 0. Both pins are therefore released.
- R8: Open-drain use works as intended. A masked write of direction 0 releases the pin, and the pulled-up line then reads back 1. A masked write of direction 1 with value 0 pulls the line low, and it then reads back 0. A released pin that an external device holds low reads back 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store strobe for the control word |
| wr_data | input | DATA_W | Word written when wr_en is high |
| rd_data | output | DATA_W | Current control word with sampled inputs |
| pin_in | input | NUM_PINS | Raw line level of each pin (asynchronous) |
| pin_oe | output | NUM_PINS | Pad driver enable per pin |
| pin_out | output | NUM_PINS | Pad drive level per pin |
| pin_pud | output | NUM_PINS | Pad pull-up disable per pin |

## Verification
The properties assume that `wr_data` only matters while `wr_en` is high and that reset is held for at least one edge. They also assume that `pin_in` is stable around each rising edge, so that the synchroniser's delay is exactly two edges and never a metastable extra cycle. The bench changes `wr_en`, `wr_data` and the external pull-down only on falling edges. It derives `pin_in` from those signals and from the pad outputs as a wired-AND line, so every input change falls half a cycle away from a sampling edge. The synchroniser check only starts once two edges have passed since reset.

// File: rtl/odgp_pkg.sv
package odgp_pkg;

  // Field offsets inside one pin lane. Bench and checker rely on these positions.
  localparam int unsigned OFS_DIR  = 0;
  localparam int unsigned OFS_DIRM = 1;
  localparam int unsigned OFS_VAL  = 2;
  localparam int unsigned OFS_VALM = 3;
  localparam int unsigned OFS_IN   = 4;
  localparam int unsigned OFS_PUD  = 5;
  localparam int unsigned MIN_LANE = 6;

  // Masked field update: take the new bit only when its enable is set.
  function automatic logic pick_field(input logic cur, input logic nxt, input logic en);
    return en ? nxt : cur;
  endfunction

  // Absolute bit index of a field in a given pin lane.
  function automatic int unsigned lane_bit(input int unsigned pin,
                                           input int unsigned lane_w,
                                           input int unsigned ofs);
    return pin * lane_w + ofs;
  endfunction

endpackage

// File: rtl/odgp_lane.sv
module odgp_lane
  import odgp_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] lane_wr,
  output logic              dir_q,
  output logic              val_q,
  output logic              pud_q,
  output logic              dir_upd,
  output logic              val_upd
);

  logic unused_lane;
  assign unused_lane = ^lane_wr;

  // Named events: a write whose enable bit selects this field.
  assign dir_upd = wr_en & lane_wr[OFS_DIRM];
  assign val_upd = wr_en & lane_wr[OFS_VALM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      val_q <= 1'b0;
      pud_q <= 1'b0;
    end else if (wr_en) begin
      dir_q <= pick_field(dir_q, lane_wr[OFS_DIR], lane_wr[OFS_DIRM]);
      val_q <= pick_field(val_q, lane_wr[OFS_VAL], lane_wr[OFS_VALM]);
      pud_q <= lane_wr[OFS_PUD];
    end
  end

endmodule

// File: rtl/odgp_sync.sv
module odgp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/odgpio_pair.sv
module odgpio_pair
  import odgp_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned LANE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_pud
);

  localparam int unsigned USED_W = NUM_PINS * LANE_W;

  initial begin
    if (USED_W > DATA_W || LANE_W < MIN_LANE || SYNC_STAGES < 2)
      $error("odgpio_pair: parameter set does not fit the control word");
  end

  logic [NUM_PINS-1:0] dir_q, val_q, pud_q, in_sync;
  logic [NUM_PINS-1:0] dir_upd, val_upd;

  logic unused_wr;
  assign unused_wr = ^wr_data;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    odgp_lane #(.LANE_W(LANE_W)) lane_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .lane_wr (wr_data[p*LANE_W +: LANE_W]),
      .dir_q   (dir_q[p]),
      .val_q   (val_q[p]),
      .pud_q   (pud_q[p]),
      .dir_upd (dir_upd[p]),
      .val_upd (val_upd[p])
    );

    odgp_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in[p]),
      .q     (in_sync[p])
    );
  end

  // Open-drain pad control: enable follows direction, level follows stored value.
  assign pin_oe  = dir_q;
  assign pin_out = val_q;
  assign pin_pud = pud_q;

  // Read word: enable bits and unused bits stay 0.
  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      rd_data[lane_bit(p, LANE_W, OFS_DIR)] = dir_q[p];
      rd_data[lane_bit(p, LANE_W, OFS_VAL)] = val_q[p];
      rd_data[lane_bit(p, LANE_W, OFS_IN)]  = in_sync[p];
      rd_data[lane_bit(p, LANE_W, OFS_PUD)] = pud_q[p];
    end
  end

endmodule

// File: rtl/odgp_chk.sv
module odgp_chk
  import odgp_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned LANE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [DATA_W-1:0]   wr_data,
  input logic [DATA_W-1:0]   rd_data,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_pud,
  input logic [NUM_PINS-1:0] dir_upd,
  input logic [NUM_PINS-1:0] val_upd
);

  logic unused_chk;
  assign unused_chk = ^{wr_data, rd_data, pin_in};

  // Edges seen since reset, saturating once the synchroniser is full.
  logic [7:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)                   since_rst <= '0;
    else if (since_rst < 8'(SYNC_STAGES)) since_rst <= since_rst + 8'd1;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    localparam int unsigned B = p * LANE_W;

    p_dir_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dir_upd[p] |=> pin_oe[p] == $past(wr_data[B+OFS_DIR]));
    p_val_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      val_upd[p] |=> pin_out[p] == $past(wr_data[B+OFS_VAL]));
    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_upd[p] |=> $stable(pin_oe[p]));
    p_val_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !val_upd[p] |=> $stable(pin_out[p]));
    p_pud_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> pin_pud[p] == $past(wr_data[B+OFS_PUD]));
    p_pud_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(pin_pud[p]));
    p_mask_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[B+OFS_DIRM] == 1'b0 && rd_data[B+OFS_VALM] == 1'b0);
    p_read_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[B+OFS_DIR] == pin_oe[p] && rd_data[B+OFS_VAL] == pin_out[p] &&
      rd_data[B+OFS_PUD] == pin_pud[p]);

    if (SYNC_STAGES == 2) begin : g_sync2
      p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 8'd2) |-> rd_data[B+OFS_IN] == $past(pin_in[p], 2));
    end
  end

endmodule

bind odgpio_pair odgp_chk #(
  .NUM_PINS(NUM_PINS), .LANE_W(LANE_W), .SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pud(pin_pud),
  .dir_upd(dir_upd), .val_upd(val_upd)
);

// File: tb/odgpio_pair_tb_top.sv
`timescale 1ns/1ps
module odgpio_pair_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  pin_in, pin_oe, pin_out, pin_pud;
  logic [1:0]  ext_low = 2'b00;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  // Wired-AND line: low if the block drives 0 or an external device pulls low.
  for (genvar p = 0; p < 2; p++) begin : g_line
    assign pin_in[p] = ~((pin_oe[p] & ~pin_out[p]) | ext_low[p]);
  end

  odgpio_pair dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pud(pin_pud)
  );

  // Behavioural reference: plain integers, lanes at 8-bit spacing.
  int m_dir[2], m_val[2], m_pud[2], m_s0[2], m_s1[2];

  always @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      int line;
      int b;
      b = 8 * p;
      line = ((m_dir[p] == 1 && m_val[p] == 0) || ext_low[p]) ? 0 : 1;
      if (!rst_n) begin
        m_dir[p] = 0; m_val[p] = 0; m_pud[p] = 0; m_s0[p] = 0; m_s1[p] = 0;
      end else begin
        m_s1[p] = m_s0[p];
        m_s0[p] = line;
        if (wr_en) begin
          if (wr_data[b+1]) m_dir[p] = int'(wr_data[b]);
          if (wr_data[b+3]) m_val[p] = int'(wr_data[b+2]);
          m_pud[p] = int'(wr_data[b+5]);
        end
      end
    end
  end

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int p = 0; p < 2; p++) begin
      w[8*p]   = m_dir[p][0];
      w[8*p+2] = m_val[p][0];
      w[8*p+4] = m_s1[p][0];
      w[8*p+5] = m_pud[p][0];
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] e;
      logic [1:0] eo, ev, ep;
      e = model_word();
      eo = {m_dir[1][0], m_dir[0][0]};
      ev = {m_val[1][0], m_val[0][0]};
      ep = {m_pud[1][0], m_pud[0][0]};
      check((rd_data & 32'h0505) == (e & 32'h0505), "R1 R2 fields", rd_data & 32'h0505, e & 32'h0505);
      check((rd_data & ~32'h3535) == 32'h0, "R4 zero bits", rd_data & ~32'h3535, 32'h0);
      check((rd_data & 32'h2020) == (e & 32'h2020) && pin_pud == ep, "R3 pud", {pin_pud, rd_data[29:0]}, {ep, e[29:0]});
      check((rd_data & 32'h1010) == (e & 32'h1010), "R6 input", rd_data & 32'h1010, e & 32'h1010);
      check(pin_oe == eo && pin_out == ev, "R5 pads", {28'h0, pin_oe, pin_out}, {28'h0, eo, ev});
    end
  end

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = $urandom;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R7: reset state, still in reset
    check(rd_data == 32'h0 && pin_oe == 2'b00 && pin_out == 2'b00 && pin_pud == 2'b00,
          "R7 reset", {rd_data[31:6], pin_oe, pin_out, pin_pud}, 32'h0);
    rst_n = 1'b1;

    // R8: release both pins with direction enable, line pulled high
    do_write(32'h0000_0202);
    repeat (3) @(negedge clk);
    check(pin_oe == 2'b00 && rd_data[4] && rd_data[12], "R8 release reads 1", rd_data, 32'h1010);

    // R8: drive both low (dir=1, both enables, value 0)
    do_write(32'h0000_0B0B);
    repeat (3) @(negedge clk);
    check(pin_oe == 2'b11 && pin_out == 2'b00 && !rd_data[4] && !rd_data[12],
          "R8 drive low reads 0", rd_data, 32'h0101);

    // R2: enables clear, every other bit set; fields must hold, R3 pud loads
    do_write(~32'h0000_0A0A);
    @(negedge clk);
    check(pin_oe == 2'b11 && pin_out == 2'b00, "R2 hold without enable", {30'h0, pin_oe}, 32'h3);
    check(pin_pud == 2'b11, "R3 pud loads ignoring enables", {30'h0, pin_pud}, 32'h3);

    // R1: value-only write to pin 1 sets value, direction unchanged
    do_write(32'h0000_0C00);
    @(negedge clk);
    check(pin_oe == 2'b11 && pin_out == 2'b10, "R1 value-only write", {28'h0, pin_oe, pin_out}, 32'hE);

    // R8: release pin 0 while an external device holds it low
    ext_low = 2'b01;
    do_write(32'h0000_0002);
    repeat (3) @(negedge clk);
    check(pin_oe[0] == 1'b0 && !rd_data[4], "R8 external low on released pin", rd_data, 32'h0);
    ext_low = 2'b00;
    repeat (3) @(negedge clk);
    check(rd_data[4] == 1'b1, "R6 input follows line", rd_data, 32'h10);

    // Mixed traffic, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en = ($urandom % 3) == 0;
      wr_data = $urandom;
      if (($urandom % 8) == 0) ext_low = 2'($urandom);
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog R1 act=%h exp=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule